// File: doc/BRIEF.md
# Power-of-Two Protection Region Matcher

This block checks a single memory protection entry against one physical access, with no clock. It takes three inputs: the entry's 8-bit configuration byte, the entry's address register, and an access (a physical address plus an access type of read, write or execute). It reports two things. The first is whether the address lies inside the entry's region. The second is whether the entry grants the requested kind of access.

Two region encodings are decoded:
- **Four-byte mode:** the region is the single word that the address register points at.
- **Naturally aligned power-of-two mode:** the region's size is carried in the run of trailing ones at the bottom of the address register.

The decoded region base and size order are also brought out for debug readback. Entries whose mode is off or top-of-range never match. Priority between several entries is handled by the surrounding logic, which places one instance per entry.

The address register holds the physical address shifted right by two. It is therefore `PAW-2` bits wide, and the smallest region the block can describe is four bytes.

Top module: `pmpm_region_match`

## Requirements
- R1: The configuration byte is decoded as follows:
  - bit 0 grants read, bit 1 grants write, bit 2 grants execute;
  - bits 4:3 select the mode: 0 = off, 1 = top-of-range, 2 = four-byte, 3 = power-of-two.

  With mode 0 or 1, `hit_o` and `allow_o` are 0 and `base_o` and `order_o` are 0, whatever the address.
- R2: In four-byte mode, `order_o` is 2 and `base_o` is the address register shifted left by 2. `hit_o` is 1 exactly when bits PAW-1:2 of the access address equal the address register.
- R3: In power-of-two mode, let t be the number of consecutive ones from bit 0 of the address register, with t less than the register width. Then `order_o` is t+3, and `base_o` is the register with its low t bits cleared, shifted left by 2.
- R4: In power-of-two mode, `hit_o` is 1 exactly when the access address lies in the range from `base_o` to `base_o` + 2^`order_o` − 1.
- R5: In power-of-two mode with an address register of all ones, the region covers the whole address space: `base_o` is 0, `order_o` is PAW, and every address hits.
- R6: The access type is encoded as 0 = read, 1 = write, 2 = execute, 3 = reserved. `allow_o` is 1 exactly when `hit_o` is 1 and the permission bit for that type (bit 0, 1 or 2 of the configuration byte) is set. A reserved access type is never allowed.
- R7: The reported `base_o` is always a multiple of 2^`order_o`.
- R8: Configuration bits 7:5 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cfg_i | input | 8 | Entry configuration byte (permissions, mode, spare bits) |
| addr_reg_i | input | PAW-2 | Entry address register (physical address shifted right by 2) |
| acc_addr_i | input | PAW | Physical address of the access |
| acc_type_i | input | 2 | Access type: 0 read, 1 write, 2 execute, 3 reserved |
| hit_o | output | 1 | Access address lies in the entry's region |
| allow_o | output | 1 | Region hit and the access type is permitted |
| base_o | output | PAW | Decoded region base address |
| order_o | output | $clog2(PAW+1) | Decoded region size as log2 of bytes |

## Verification
The hardest situations to reach are the edges of the trailing-ones decode:
- a register with all ones except the top bit, which gives a region covering the whole space but decoded through the ordinary path;
- the all-ones register, which takes the whole-space path.

The bench does not pick register values at random. For each chosen size order it encodes the register from a base and that order, which lands on these edges deliberately. It then probes the first and last byte inside the region and the bytes just outside it.

// File: rtl/pmpm_pkg.sv
package pmpm_pkg;

  // Mode field of the configuration byte (bits 4:3)
  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_TOR   = 2'd1,
    MODE_NA4   = 2'd2,
    MODE_NAPOT = 2'd3
  } mode_e;

  // Kind of access being checked
  typedef enum logic [1:0] {
    ACC_RD   = 2'd0,
    ACC_WR   = 2'd1,
    ACC_EX   = 2'd2,
    ACC_RSVD = 2'd3
  } acc_e;

  // Configuration byte, MSB first
  typedef struct packed {
    logic [2:0] spare;
    mode_e      mode;
    logic       perm_x;
    logic       perm_w;
    logic       perm_r;
  } cfg_t;

  localparam int GRAIN_SHIFT = 2;

endpackage

// File: rtl/pmpm_ones_count.sv
module pmpm_ones_count #(
  parameter int W = 30,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec_i,
  output logic [CW-1:0] cnt_o
);

  // Length of the run of ones starting at bit 0
  function automatic logic [CW-1:0] trailing_ones(input logic [W-1:0] v);
    logic [CW-1:0] n;
    logic          run;
    n   = '0;
    run = 1'b1;
    for (int i = 0; i < W; i++) begin
      run = run & v[i];
      if (run) n = n + CW'(1);
    end
    return n;
  endfunction

  assign cnt_o = trailing_ones(vec_i);

endmodule

// File: rtl/pmpm_region_dec.sv
module pmpm_region_dec
  import pmpm_pkg::*;
#(
  parameter int PAW = 32,
  localparam int RW = PAW - GRAIN_SHIFT,
  localparam int OW = $clog2(PAW + 1),
  localparam int CW = $clog2(RW + 1)
) (
  input  mode_e          mode_i,
  input  logic [RW-1:0]  addr_reg_i,
  output logic           valid_o,
  output logic           whole_o,
  output logic [PAW-1:0] base_o,
  output logic [OW-1:0]  order_o,
  output logic [PAW-1:0] keep_o
);

  logic [CW-1:0] ones_cnt;

  pmpm_ones_count #(.W(RW)) u_ones (
    .vec_i (addr_reg_i),
    .cnt_o (ones_cnt)
  );

  // Clear bits below position n
  function automatic logic [RW-1:0] clear_low(input logic [RW-1:0] v,
                                              input logic [CW-1:0] n);
    logic [RW-1:0] r;
    for (int i = 0; i < RW; i++) r[i] = (i < int'(n)) ? 1'b0 : v[i];
    return r;
  endfunction

  // Bits at or above position ord take part in the compare
  function automatic logic [PAW-1:0] keep_mask(input logic [OW-1:0] ord);
    logic [PAW-1:0] m;
    for (int i = 0; i < PAW; i++) m[i] = (i >= int'(ord));
    return m;
  endfunction

  logic [OW-1:0] napot_order;
  assign napot_order = OW'(ones_cnt) + OW'(3);

  always_comb begin
    valid_o = 1'b0;
    whole_o = 1'b0;
    base_o  = '0;
    order_o = '0;
    keep_o  = '0;
    case (mode_i)
      MODE_NA4: begin
        valid_o = 1'b1;
        base_o  = {addr_reg_i, 2'b00};
        order_o = OW'(GRAIN_SHIFT);
        keep_o  = keep_mask(OW'(GRAIN_SHIFT));
      end
      MODE_NAPOT: begin
        valid_o = 1'b1;
        if (int'(ones_cnt) == RW) begin
          whole_o = 1'b1;
          order_o = OW'(PAW);
        end else begin
          base_o  = {clear_low(addr_reg_i, ones_cnt), 2'b00};
          order_o = napot_order;
          keep_o  = keep_mask(napot_order);
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/pmpm_perm_check.sv
module pmpm_perm_check
  import pmpm_pkg::*;
(
  input  logic perm_r_i,
  input  logic perm_w_i,
  input  logic perm_x_i,
  input  acc_e acc_type_i,
  input  logic hit_i,
  output logic perm_sel_o,
  output logic allow_o
);

  always_comb begin
    case (acc_type_i)
      ACC_RD:  perm_sel_o = perm_r_i;
      ACC_WR:  perm_sel_o = perm_w_i;
      ACC_EX:  perm_sel_o = perm_x_i;
      default: perm_sel_o = 1'b0;
    endcase
  end

  assign allow_o = hit_i & perm_sel_o;

endmodule

// File: rtl/pmpm_region_match.sv
module pmpm_region_match
  import pmpm_pkg::*;
#(
  parameter int PAW = 32,
  localparam int OW = $clog2(PAW + 1)
) (
  input  logic [7:0]     cfg_i,
  input  logic [PAW-3:0] addr_reg_i,
  input  logic [PAW-1:0] acc_addr_i,
  input  logic [1:0]     acc_type_i,
  output logic           hit_o,
  output logic           allow_o,
  output logic [PAW-1:0] base_o,
  output logic [OW-1:0]  order_o
);

  cfg_t           cfg_s;
  mode_e          mode_w;
  logic           dec_valid;
  logic           dec_whole;
  logic [PAW-1:0] dec_keep;
  logic           perm_sel;
  logic [2:0]     unused_cfg_spare;

  assign cfg_s            = cfg_i;
  assign mode_w           = cfg_s.mode;
  assign unused_cfg_spare = cfg_s.spare;

  pmpm_region_dec #(.PAW(PAW)) u_dec (
    .mode_i     (mode_w),
    .addr_reg_i (addr_reg_i),
    .valid_o    (dec_valid),
    .whole_o    (dec_whole),
    .base_o     (base_o),
    .order_o    (order_o),
    .keep_o     (dec_keep)
  );

  assign hit_o = dec_valid & ((acc_addr_i & dec_keep) == base_o);

  pmpm_perm_check u_perm (
    .perm_r_i   (cfg_s.perm_r),
    .perm_w_i   (cfg_s.perm_w),
    .perm_x_i   (cfg_s.perm_x),
    .acc_type_i (acc_e'(acc_type_i)),
    .hit_i      (hit_o),
    .perm_sel_o (perm_sel),
    .allow_o    (allow_o)
  );

endmodule

// File: rtl/pmpm_region_match_chk.sv
module pmpm_region_match_chk #(
  parameter int PAW = 32,
  localparam int OW = $clog2(PAW + 1)
) (
  input logic [7:0]     cfg_i,
  input logic [PAW-1:0] acc_addr_i,
  input logic [1:0]     acc_type_i,
  input logic           hit_o,
  input logic           allow_o,
  input logic [PAW-1:0] base_o,
  input logic [OW-1:0]  order_o,
  input logic           dec_whole
);

  always_comb begin
    if (cfg_i[4:3] == 2'd0 || cfg_i[4:3] == 2'd1)
      AST_OFF_NO_HIT: assert (!hit_o && !allow_o) else $error("off entry hit"); // R1
    if (cfg_i[4:3] == 2'd2)
      AST_NA4_ORDER: assert (order_o == OW'(2)) else $error("four-byte order"); // R2
    if (hit_o)
      AST_HIT_IN_REGION: assert ((acc_addr_i >> order_o) == (base_o >> order_o)) else $error("hit outside region"); // R4
    if (dec_whole)
      AST_WHOLE_HITS: assert (hit_o && base_o == '0) else $error("whole space miss"); // R5
    if (allow_o)
      AST_ALLOW_NEEDS_HIT: assert (hit_o && acc_type_i != 2'd3) else $error("allow without hit"); // R6
    if (allow_o && acc_type_i == 2'd1)
      AST_WRITE_NEEDS_W: assert (cfg_i[1]) else $error("write without permission"); // R6
    AST_BASE_ALIGNED: assert (((base_o >> order_o) << order_o) == base_o) else $error("base misaligned"); // R7
  end

endmodule

bind pmpm_region_match pmpm_region_match_chk #(.PAW(PAW)) u_chk (
  .cfg_i      (cfg_i),
  .acc_addr_i (acc_addr_i),
  .acc_type_i (acc_type_i),
  .hit_o      (hit_o),
  .allow_o    (allow_o),
  .base_o     (base_o),
  .order_o    (order_o),
  .dec_whole  (dec_whole)
);

// File: tb/tb_pmpm_region_match.sv
module tb_pmpm_region_match;

  localparam int CLK_PERIOD = 10;
  localparam int PAW = 32;
  localparam int OW = $clog2(PAW + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [7:0]     cfg;
  logic [PAW-3:0] areg;
  logic [PAW-1:0] addr;
  logic [1:0]     at;
  logic           hit, allow;
  logic [PAW-1:0] base;
  logic [OW-1:0]  order;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  pmpm_region_match #(.PAW(PAW)) dut (
    .cfg_i (cfg), .addr_reg_i (areg), .acc_addr_i (addr), .acc_type_i (at),
    .hit_o (hit), .allow_o (allow), .base_o (base), .order_o (order)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got=%0h exp=%0h", req, what, got, exp);
    end
  endtask

  function automatic logic [7:0] mkcfg(input logic [1:0] mode, input logic [2:0] perm);
    return {3'b000, mode, perm};
  endfunction

  // Software-side encoding of a 2^k region (k >= 3)
  function automatic logic [PAW-3:0] enc_napot(input logic [63:0] b, input int k);
    logic [63:0] m;
    m = (64'd1 << (k - 2)) - 1;
    return (PAW-2)'(((b >> 2) & ~m) | (m >> 1));
  endfunction

  function automatic bit in_region(input logic [63:0] a, input logic [63:0] b, input int k);
    return (a >= b) && (a < b + (64'd1 << k));
  endfunction

  task automatic apply(input logic [7:0] c, input logic [PAW-3:0] r,
                       input logic [PAW-1:0] a, input logic [1:0] t);
    @(negedge clk);
    cfg = c; areg = r; addr = a; at = t;
    #1;
  endtask

  task automatic t_reset;
    chk("R1", "reset hit", 64'(hit), 0);
    chk("R1", "reset allow", 64'(allow), 0);
    chk("R1", "reset base", 64'(base), 0);
    chk("R1", "reset order", 64'(order), 0);
  endtask

  task automatic t_off_tor;
    for (int m = 0; m < 2; m++) begin
      apply(mkcfg(2'(m), 3'b111), 30'h0400_0004, 32'h1000_0010, 2'd0);
      chk("R1", "off/tor hit", 64'(hit), 0);
      chk("R1", "off/tor allow", 64'(allow), 0);
      chk("R1", "off/tor base", 64'(base), 0);
      chk("R1", "off/tor order", 64'(order), 0);
    end
  endtask

  task automatic t_na4;
    logic [63:0] b;
    b = 64'h1000_0010;
    apply(mkcfg(2'd2, 3'b001), PAW'(b >> 2) , PAW'(b), 2'd0);
    chk("R2", "na4 order", 64'(order), 2);
    chk("R2", "na4 base", 64'(base), b);
    chk("R2", "na4 first byte", 64'(hit), 1);
    apply(mkcfg(2'd2, 3'b001), (PAW-2)'(b >> 2), PAW'(b + 3), 2'd0);
    chk("R2", "na4 last byte", 64'(hit), 1);
    apply(mkcfg(2'd2, 3'b001), (PAW-2)'(b >> 2), PAW'(b + 4), 2'd0);
    chk("R2", "na4 after", 64'(hit), 0);
    apply(mkcfg(2'd2, 3'b001), (PAW-2)'(b >> 2), PAW'(b - 1), 2'd0);
    chk("R2", "na4 before", 64'(hit), 0);
  endtask

  task automatic t_napot;
    int ks[5] = '{3, 12, 20, 31, 32};
    foreach (ks[j]) begin
      int k = ks[j];
      logic [63:0] b, sz;
      logic [PAW-3:0] r;
      sz = 64'd1 << k;
      b  = 64'hA5A5_6C38 & ~(sz - 1) & 64'hFFFF_FFFF;
      r  = enc_napot(b, k);
      apply(mkcfg(2'd3, 3'b001), r, PAW'(b), 2'd0);
      chk("R3", $sformatf("napot order k=%0d", k), 64'(order), 64'(k));
      chk("R3", $sformatf("napot base k=%0d", k), 64'(base), b);
      chk("R7", $sformatf("napot aligned k=%0d", k), 64'(base) & (sz - 1), 0);
      chk("R4", $sformatf("napot first k=%0d", k), 64'(hit), 1);
      apply(mkcfg(2'd3, 3'b001), r, PAW'(b + sz - 1), 2'd0);
      chk("R4", $sformatf("napot last k=%0d", k), 64'(hit), 1);
      if (b + sz < (64'd1 << PAW)) begin
        apply(mkcfg(2'd3, 3'b001), r, PAW'(b + sz), 2'd0);
        chk("R4", $sformatf("napot after k=%0d", k), 64'(hit), 64'(in_region(b + sz, b, k)));
      end
      if (b != 0) begin
        apply(mkcfg(2'd3, 3'b001), r, PAW'(b - 1), 2'd0);
        chk("R4", $sformatf("napot before k=%0d", k), 64'(hit), 0);
      end
    end
  endtask

  task automatic t_whole;
    logic [31:0] probes[3] = '{32'h0, 32'hFFFF_FFFF, 32'h1234_5678};
    foreach (probes[j]) begin
      apply(mkcfg(2'd3, 3'b100), '1, probes[j], 2'd2);
      chk("R5", "whole order", 64'(order), 64'(PAW));
      chk("R5", "whole base", 64'(base), 0);
      chk("R5", "whole hit", 64'(hit), 1);
      chk("R6", "whole exec allow", 64'(allow), 1);
    end
  endtask

  task automatic t_perm;
    for (int p = 0; p < 8; p++) begin
      for (int t = 0; t < 4; t++) begin
        bit exp_allow;
        exp_allow = (t < 3) && p[t];
        apply(mkcfg(2'd2, 3'(p)), 30'h0000_0100, 32'h0000_0402, 2'(t));
        chk("R6", $sformatf("perm p=%0d t=%0d", p, t), 64'(allow), 64'(exp_allow));
      end
      apply(mkcfg(2'd2, 3'(p)), 30'h0000_0100, 32'h0000_0408, 2'd0);
      chk("R6", $sformatf("perm miss p=%0d", p), 64'(allow), 0);
    end
  endtask

  task automatic t_spare;
    logic [PAW-3:0] r;
    r = enc_napot(64'h0000_8000, 12);
    for (int s = 0; s < 8; s++) begin
      apply({3'(s), 2'b11, 3'b010}, r, 32'h0000_8FFC, 2'd1);
      chk("R8", $sformatf("spare=%0d hit", s), 64'(hit), 1);
      chk("R8", $sformatf("spare=%0d allow", s), 64'(allow), 1);
      chk("R8", $sformatf("spare=%0d base", s), 64'(base), 64'h8000);
      chk("R8", $sformatf("spare=%0d order", s), 64'(order), 12);
      apply({3'(s), 2'b11, 3'b010}, r, 32'h0000_9000, 2'd1);
      chk("R8", $sformatf("spare=%0d miss", s), 64'(hit), 0);
    end
  endtask

  initial begin
    cfg = '0; areg = '0; addr = '0; at = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_off_tor();
    t_na4();
    t_napot();
    t_whole();
    t_perm();
    t_spare();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: got=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule